// File: doc/BRIEF.md
# Rank-Switch Gap Command Scheduler

This block picks, on every clock cycle, at most one command from a set of pending read and write requests, one request line per rank and direction. It keeps the data bus safe when the stream changes rank: after a read, reads to any other rank are held off for a programmable number of idle clocks, and writes have their own separately programmed idle count. Reads to the rank that was just served stay eligible during that window, so a busy rank can keep the bus without losing cycles.

To stop one rank from holding the bus for too long, the block counts the reads granted in a row to one rank. When that count reaches a programmable limit, every read is held off for the read gap, and the next read grant goes round-robin to the first requesting rank after the one just served. A limit of zero turns this off. The three settings are static: they are captured only while reset is asserted. The grant is registered, so it appears one cycle after the requests it answers.

Top module: `rank_gap_sched`

## Requirements
- R1: After a read grant to rank A, a read to any other rank is granted only after at least `cfg_rd_gap_in` cycles with no read grant. Reads to rank A stay eligible during that window, and each such read restarts the window.
- R2: After a write grant to rank A, a write to any other rank is granted only after at least `cfg_wr_gap_in` cycles with no write grant. Writes to rank A stay eligible during that window.
- R3: While the rank last served in a direction is still requesting and eligible, it keeps the grant. Same-rank reads below the limit go out on consecutive cycles with no gap.
- R4: When the count of consecutive reads to one rank reaches a non-zero `cfg_rd_cap_in`, no read is granted for the next read-gap cycles. The next read then goes round-robin, starting after the rank just served, and the count starts again.
- R5: A read limit of 0 turns the limit off: a rank that keeps requesting keeps the read grant for as long as it requests.
- R6: A grant in one direction clears the other direction's gap window and clears the consecutive-read count. A change of direction never waits for a rank gap.
- R7: When an eligible read and an eligible write are both pending, the read wins.
- R8: With no last-rank preference in force, the grant goes to the first requesting eligible rank in index order starting after the last-served rank and wrapping. Out of reset the search starts at rank 0.
- R9: On each reset clock edge the settings are loaded from the inputs when `cfg_load` is 1 and from the defaults (write gap 6, read gap 6, read limit 15) when it is 0. Outside reset, `cfg_load` and the setting inputs have no effect.
- R10: `gnt_valid` is 0 during reset. A grant shows the answered request one clock later: at most one bit set in `gnt_rank_oh`, `gnt_is_wr` 1 for a write, and always a request that was pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Take settings from the inputs while in reset |
| cfg_wr_gap_in | input | 4 | Idle clocks between writes to different ranks |
| cfg_rd_gap_in | input | 4 | Idle clocks between reads to different ranks |
| cfg_rd_cap_in | input | 4 | Maximum consecutive reads to one rank, 0 = no limit |
| rd_req | input | NUM_RANKS | Read pending, one bit per rank |
| wr_req | input | NUM_RANKS | Write pending, one bit per rank |
| gnt_valid | output | 1 | A command is granted this cycle |
| gnt_rank_oh | output | NUM_RANKS | One-hot rank of the grant |
| gnt_is_wr | output | 1 | Grant is a write (0 = read) |

## Verification
The bench measures the exact idle run before a rank switch in both directions. A window that is one cycle short or one cycle long shows up as a grant in the wrong row. It drives a rank that requests without a break under a small limit, the default limit and no limit. A design with the count off by one, a missing hold-off, or a round-robin pointer that does not advance or does not wrap grants the wrong rank or in the wrong cycle. It also tries reads and writes that collide, changes of direction in the middle of a gap (a design that carries the gap across directions stalls there), and writes to the settings after reset, which must not change the grant pattern.

// File: rtl/rgs_pkg.sv
package rgs_pkg;

    localparam int CFG_W = 4;

    typedef logic [CFG_W-1:0] cfg_val_t;

    typedef struct packed {
        cfg_val_t wr_gap;
        cfg_val_t rd_gap;
        cfg_val_t rd_cap;
    } rgs_cfg_t;

    localparam cfg_val_t DEF_WR_GAP = CFG_W'(6);
    localparam cfg_val_t DEF_RD_GAP = CFG_W'(6);
    localparam cfg_val_t DEF_RD_CAP = CFG_W'(15);

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } rgs_dir_e;

endpackage

// File: rtl/rgs_cfg_reg.sv
module rgs_cfg_reg
    import rgs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  cfg_val_t wr_gap_in,
    input  cfg_val_t rd_gap_in,
    input  cfg_val_t rd_cap_in,
    output rgs_cfg_t cfg
);

    rgs_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            if (load) begin
                cfg_d.wr_gap = wr_gap_in;
                cfg_d.rd_gap = rd_gap_in;
                cfg_d.rd_cap = rd_cap_in;
            end else begin
                cfg_d.wr_gap = DEF_WR_GAP;
                cfg_d.rd_gap = DEF_RD_GAP;
                cfg_d.rd_cap = DEF_RD_CAP;
            end
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/rgs_dir_track.sv
module rgs_dir_track
    import rgs_pkg::*;
#(
    parameter  int NUM_RANKS = 4,
    parameter  bit HAS_CAP   = 1'b0,
    localparam int RANK_W    = $clog2(NUM_RANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 grant_this,
    input  logic                 grant_other,
    input  logic [RANK_W-1:0]    grant_rank,
    input  cfg_val_t             gap_len,
    input  cfg_val_t             cap_len,
    output logic [NUM_RANKS-1:0] eligible,
    output logic [RANK_W-1:0]    last_rank,
    output logic                 prefer_last
);

    typedef struct packed {
        logic [RANK_W-1:0] last;
        cfg_val_t          gap;
        logic              all_blk;
        cfg_val_t          run;
        logic              fair;
    } trk_t;

    localparam trk_t TRK_RST = '{
        last:    RANK_W'(NUM_RANKS - 1),
        gap:     '0,
        all_blk: 1'b0,
        run:     '0,
        fair:    1'b1
    };

    trk_t     s_d, s_q;
    cfg_val_t run_n;

    always_comb begin
        s_d   = s_q;
        run_n = s_q.run;
        if (s_q.gap != '0) begin
            s_d.gap = s_q.gap - 1'b1;
        end
        if (grant_this) begin
            s_d.last = grant_rank;
            s_d.gap  = gap_len;
            if ((grant_rank == s_q.last) && (s_q.run != '0)) begin
                run_n = (s_q.run == '1) ? s_q.run : s_q.run + 1'b1;
            end else begin
                run_n = cfg_val_t'(1);
            end
            if (HAS_CAP && (cap_len != '0) && (run_n == cap_len)) begin
                s_d.all_blk = 1'b1;
                s_d.fair    = 1'b1;
                s_d.run     = '0;
            end else begin
                s_d.all_blk = 1'b0;
                s_d.fair    = 1'b0;
                s_d.run     = run_n;
            end
        end else if (grant_other) begin
            s_d.gap     = '0;
            s_d.all_blk = 1'b0;
            s_d.run     = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= TRK_RST;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        for (int r = 0; r < NUM_RANKS; r++) begin
            eligible[r] = (s_q.gap == '0) ||
                          (!s_q.all_blk && (RANK_W'(r) == s_q.last));
        end
    end

    assign last_rank   = s_q.last;
    assign prefer_last = !s_q.fair;

endmodule

// File: rtl/rgs_rank_pick.sv
module rgs_rank_pick #(
    parameter  int NUM_RANKS = 4,
    localparam int RANK_W    = $clog2(NUM_RANKS)
) (
    input  logic [NUM_RANKS-1:0] req,
    input  logic [NUM_RANKS-1:0] eligible,
    input  logic [RANK_W-1:0]    last_rank,
    input  logic                 prefer_last,
    output logic                 found,
    output logic [RANK_W-1:0]    pick
);

    logic [NUM_RANKS-1:0] cand;

    assign cand = req & eligible;

    always_comb begin
        found = 1'b0;
        pick  = last_rank;
        if (prefer_last && cand[last_rank]) begin
            found = 1'b1;
        end
        for (int i = 1; i <= NUM_RANKS; i++) begin
            int                idx;
            logic [RANK_W-1:0] idx_r;
            idx = int'(last_rank) + i;
            if (idx >= NUM_RANKS) begin
                idx = idx - NUM_RANKS;
            end
            idx_r = RANK_W'(idx);
            if (!found && cand[idx_r]) begin
                found = 1'b1;
                pick  = idx_r;
            end
        end
    end

endmodule

// File: rtl/rank_gap_sched.sv
module rank_gap_sched
    import rgs_pkg::*;
#(
    parameter  int NUM_RANKS = 4,
    localparam int RANK_W    = $clog2(NUM_RANKS),
    localparam int NUM_DIRS  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_load,
    input  logic [CFG_W-1:0]     cfg_wr_gap_in,
    input  logic [CFG_W-1:0]     cfg_rd_gap_in,
    input  logic [CFG_W-1:0]     cfg_rd_cap_in,
    input  logic [NUM_RANKS-1:0] rd_req,
    input  logic [NUM_RANKS-1:0] wr_req,
    output logic                 gnt_valid,
    output logic [NUM_RANKS-1:0] gnt_rank_oh,
    output logic                 gnt_is_wr
);

    typedef struct packed {
        logic                 valid;
        logic [NUM_RANKS-1:0] oh;
        rgs_dir_e             dir;
    } gnt_t;

    rgs_cfg_t             cfg_q;
    logic [NUM_DIRS-1:0]  found;
    logic [NUM_DIRS-1:0]  gnt_dir;
    logic [RANK_W-1:0]    pick_idx [NUM_DIRS];
    gnt_t                 out_d, out_q;

    rgs_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_load),
        .wr_gap_in (cfg_wr_gap_in),
        .rd_gap_in (cfg_rd_gap_in),
        .rd_cap_in (cfg_rd_cap_in),
        .cfg       (cfg_q)
    );

    // Reads take precedence over writes when both have an eligible rank.
    assign gnt_dir[DIR_RD] = found[DIR_RD];
    assign gnt_dir[DIR_WR] = !found[DIR_RD] && found[DIR_WR];

    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
        localparam bit IS_WR = (d == int'(DIR_WR));

        logic [NUM_RANKS-1:0] req_v;
        logic [NUM_RANKS-1:0] elig;
        logic [RANK_W-1:0]    last_r;
        logic                 pref;

        assign req_v = IS_WR ? wr_req : rd_req;

        rgs_dir_track #(
            .NUM_RANKS (NUM_RANKS),
            .HAS_CAP   (!IS_WR)
        ) u_trk (
            .clk         (clk),
            .rst_n       (rst_n),
            .grant_this  (gnt_dir[d]),
            .grant_other (gnt_dir[NUM_DIRS-1-d]),
            .grant_rank  (pick_idx[d]),
            .gap_len     (IS_WR ? cfg_q.wr_gap : cfg_q.rd_gap),
            .cap_len     (cfg_q.rd_cap),
            .eligible    (elig),
            .last_rank   (last_r),
            .prefer_last (pref)
        );

        rgs_rank_pick #(
            .NUM_RANKS (NUM_RANKS)
        ) u_pick (
            .req         (req_v),
            .eligible    (elig),
            .last_rank   (last_r),
            .prefer_last (pref),
            .found       (found[d]),
            .pick        (pick_idx[d])
        );
    end

    always_comb begin
        out_d = '0;
        if (gnt_dir[DIR_RD]) begin
            out_d.valid               = 1'b1;
            out_d.dir                 = DIR_RD;
            out_d.oh[pick_idx[DIR_RD]] = 1'b1;
        end else if (gnt_dir[DIR_WR]) begin
            out_d.valid               = 1'b1;
            out_d.dir                 = DIR_WR;
            out_d.oh[pick_idx[DIR_WR]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign gnt_valid   = out_q.valid;
    assign gnt_rank_oh = out_q.oh;
    assign gnt_is_wr   = (out_q.dir == DIR_WR);

endmodule

// File: rtl/rank_gap_sched_chk.sv
module rank_gap_sched_chk
    import rgs_pkg::*;
#(
    parameter int NUM_RANKS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_RANKS-1:0] rd_req,
    input logic [NUM_RANKS-1:0] wr_req,
    input logic                 gnt_valid,
    input logic [NUM_RANKS-1:0] gnt_rank_oh,
    input logic                 gnt_is_wr,
    input cfg_val_t             cfg_rd_gap,
    input cfg_val_t             cfg_wr_gap,
    input cfg_val_t             cfg_rd_cap
);

    logic                 prev_rd;
    logic [NUM_RANKS-1:0] prev_oh;
    logic [CFG_W:0]       adj_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_rd <= 1'b0;
            prev_oh <= '0;
            adj_run <= '0;
        end else begin
            prev_rd <= gnt_valid && !gnt_is_wr;
            prev_oh <= gnt_rank_oh;
            if (gnt_valid && !gnt_is_wr) begin
                if (prev_rd && (prev_oh == gnt_rank_oh)) begin
                    adj_run <= (adj_run == '1) ? adj_run : adj_run + 1'b1;
                end else begin
                    adj_run <= (CFG_W+1)'(1);
                end
            end else begin
                adj_run <= '0;
            end
        end
    end

    assert_onehot_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid ? $onehot(gnt_rank_oh) : (gnt_rank_oh == '0));

    assert_grant_was_requested_R10: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> ((gnt_rank_oh & (gnt_is_wr ? $past(wr_req) : $past(rd_req))) != '0));

    assert_read_rank_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gnt_valid && !gnt_is_wr) && gnt_valid && !gnt_is_wr && (cfg_rd_gap != '0))
            |-> (gnt_rank_oh == $past(gnt_rank_oh)));

    assert_write_rank_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gnt_valid && gnt_is_wr) && gnt_valid && gnt_is_wr && (cfg_wr_gap != '0))
            |-> (gnt_rank_oh == $past(gnt_rank_oh)));

    assert_read_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_cap != '0) |-> (adj_run <= {1'b0, cfg_rd_cap}));

    assert_cfg_static_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(cfg_rd_gap) && $stable(cfg_wr_gap) && $stable(cfg_rd_cap)));

endmodule

bind rank_gap_sched rank_gap_sched_chk #(.NUM_RANKS(NUM_RANKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_req      (rd_req),
    .wr_req      (wr_req),
    .gnt_valid   (gnt_valid),
    .gnt_rank_oh (gnt_rank_oh),
    .gnt_is_wr   (gnt_is_wr),
    .cfg_rd_gap  (cfg_q.rd_gap),
    .cfg_wr_gap  (cfg_q.wr_gap),
    .cfg_rd_cap  (cfg_q.rd_cap)
);

// File: tb/rank_gap_sched_tb.sv
module rank_gap_sched_tb;
    import rgs_pkg::*;

    localparam int NR = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    cfg_val_t      cfg_wr_gap_in = '0;
    cfg_val_t      cfg_rd_gap_in = '0;
    cfg_val_t      cfg_rd_cap_in = '0;
    logic [NR-1:0] rd_req = '0;
    logic [NR-1:0] wr_req = '0;
    logic          gnt_valid;
    logic [NR-1:0] gnt_rank_oh;
    logic          gnt_is_wr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rank_gap_sched #(.NUM_RANKS(NR)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_load      (cfg_load),
        .cfg_wr_gap_in (cfg_wr_gap_in),
        .cfg_rd_gap_in (cfg_rd_gap_in),
        .cfg_rd_cap_in (cfg_rd_cap_in),
        .rd_req        (rd_req),
        .wr_req        (wr_req),
        .gnt_valid     (gnt_valid),
        .gnt_rank_oh   (gnt_rank_oh),
        .gnt_is_wr     (gnt_is_wr)
    );

    typedef struct packed {
        logic [NR-1:0] rd;
        logic [NR-1:0] wr;
        logic          ev;
        logic [NR-1:0] eoh;
        logic          ew;
    } vec_t;

    // Default settings: both gaps 6, read limit 15.
    localparam vec_t VEC [0:21] = '{
        '{4'b0001, 4'b0000, 1'b1, 4'b0001, 1'b0},
        '{4'b0011, 4'b0000, 1'b1, 4'b0001, 1'b0},
        '{4'b0010, 4'b0000, 1'b0, 4'b0000, 1'b0},
        '{4'b0010, 4'b0000, 1'b0, 4'b0000, 1'b0},
        '{4'b0010, 4'b0000, 1'b0, 4'b0000, 1'b0},
        '{4'b0010, 4'b0000, 1'b0, 4'b0000, 1'b0},
        '{4'b0010, 4'b0000, 1'b0, 4'b0000, 1'b0},
        '{4'b0010, 4'b0000, 1'b0, 4'b0000, 1'b0},
        '{4'b0010, 4'b0000, 1'b1, 4'b0010, 1'b0},
        '{4'b0100, 4'b1000, 1'b1, 4'b1000, 1'b1},
        '{4'b0100, 4'b0000, 1'b1, 4'b0100, 1'b0},
        '{4'b0000, 4'b0001, 1'b1, 4'b0001, 1'b1},
        '{4'b0000, 4'b0011, 1'b1, 4'b0001, 1'b1},
        '{4'b0000, 4'b0010, 1'b0, 4'b0000, 1'b0},
        '{4'b0000, 4'b0010, 1'b0, 4'b0000, 1'b0},
        '{4'b0000, 4'b0010, 1'b0, 4'b0000, 1'b0},
        '{4'b0000, 4'b0010, 1'b0, 4'b0000, 1'b0},
        '{4'b0000, 4'b0010, 1'b0, 4'b0000, 1'b0},
        '{4'b0000, 4'b0010, 1'b0, 4'b0000, 1'b0},
        '{4'b0000, 4'b0010, 1'b1, 4'b0010, 1'b1},
        '{4'b0010, 4'b0010, 1'b1, 4'b0010, 1'b0},
        '{4'b0000, 4'b0000, 1'b0, 4'b0000, 1'b0}
    };

    task automatic expect_gnt(input string tag, input logic ev,
                              input logic [NR-1:0] eoh, input logic ew);
        n_chk++;
        if ({gnt_valid, gnt_rank_oh, gnt_is_wr} !== {ev, eoh, ew}) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b oh=%b wr=%0b expected valid=%0b oh=%b wr=%0b",
                     tag, gnt_valid, gnt_rank_oh, gnt_is_wr, ev, eoh, ew);
        end
    endtask

    task automatic step(input logic [NR-1:0] rd, input logic [NR-1:0] wr);
        rd_req = rd;
        wr_req = wr;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset(input logic load, input cfg_val_t wg,
                            input cfg_val_t rg, input cfg_val_t cap);
        rst_n         = 1'b0;
        rd_req        = '0;
        wr_req        = '0;
        cfg_load      = load;
        cfg_wr_gap_in = wg;
        cfg_rd_gap_in = rg;
        cfg_rd_cap_in = cap;
        repeat (3) @(posedge clk);
        #2;
        expect_gnt("R10 no grant in reset", 1'b0, '0, 1'b0);
        rst_n    = 1'b1;
        cfg_load = 1'b0;
    endtask

    function automatic logic [NR-1:0] oh_of(input int r);
        return (r < 0) ? '0 : (NR'(1) << r);
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no finish expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // Table: default settings (R9), gaps R1 R2, preference R3,
        // direction change R6, read priority R7, round-robin R8, output R10.
        do_reset(1'b0, '0, '0, '0);
        for (int i = 0; i < 22; i++) begin
            step(VEC[i].rd, VEC[i].wr);
            expect_gnt($sformatf("R1 R2 R3 R6 R7 R8 R9 table row %0d", i),
                       VEC[i].ev, VEC[i].eoh, VEC[i].ew);
        end

        // R4: limit 3, read gap 2; ranks 0 and 1 always request.
        begin
            int exp_r4 [11] = '{0, 0, 0, -1, -1, 1, 1, 1, -1, -1, 0};
            do_reset(1'b1, cfg_val_t'(1), cfg_val_t'(2), cfg_val_t'(3));
            for (int i = 0; i < 11; i++) begin
                step(4'b0011, 4'b0000);
                expect_gnt($sformatf("R4 R8 limit cycle %0d", i),
                           exp_r4[i] >= 0, oh_of(exp_r4[i]), 1'b0);
            end
        end

        // R5: limit 0 keeps rank 0; R9: setting writes after reset ignored.
        do_reset(1'b1, cfg_val_t'(2), cfg_val_t'(2), cfg_val_t'(0));
        cfg_load      = 1'b1;
        cfg_rd_cap_in = cfg_val_t'(1);
        cfg_rd_gap_in = cfg_val_t'(0);
        for (int i = 0; i < 20; i++) begin
            step(4'b0011, 4'b0000);
            expect_gnt($sformatf("R5 R9 no limit cycle %0d", i), 1'b1, 4'b0001, 1'b0);
        end
        cfg_load = 1'b0;

        // R4 R9: default limit 15 with default gap 6.
        do_reset(1'b0, '0, '0, '0);
        for (int i = 0; i < 22; i++) begin
            step(4'b0011, 4'b0000);
            if (i < 15) begin
                expect_gnt($sformatf("R4 default limit cycle %0d", i), 1'b1, 4'b0001, 1'b0);
            end else if (i < 21) begin
                expect_gnt($sformatf("R4 default hold-off cycle %0d", i), 1'b0, 4'b0000, 1'b0);
            end else begin
                expect_gnt("R4 R8 after default hold-off", 1'b1, 4'b0010, 1'b0);
            end
        end

        step('0, '0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule